// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a ring of transmit buffer descriptors held in system memory and turns each chain of descriptors into one outgoing frame. Each descriptor is a pair of 32-bit words: a buffer address and a control word with the buffer length and three flags (final fragment, wrap to ring start, software-owned). The walker fetches descriptors through a single request/acknowledge memory port. It reads the buffer words behind them and presents the bytes one per cycle on a valid/ready byte stream, with a last marker on the closing byte.

When the descriptor that closes a frame has been streamed, the walker reads the control word of the frame's opening descriptor again, sets its ownership bit and writes it back, which hands the whole chain back to software. It then moves its ring pointer past the frame and carries on with the next descriptor. It stops at the first descriptor that software still owns. A start pulse wakes it only while transmit is enabled. Dropping the enable parks it and returns the ring pointer to the programmed queue base. Frames that grow past an internal byte limit are cut short and reported.

Top module: `txd_ring_walker`

## Requirements
- R1: Descriptor layout: word 0 (at pointer P) is the buffer byte address; word 1 (at P+4) holds length in bits 13:0, the final-fragment flag in bit 15, the wrap flag in bit 30 and the software-owned flag in bit 31. The walker reads word 0 first, then word 1, and the first descriptor read after a start is at the current ring pointer.
- R2: A descriptor whose bit 31 is 1 ends the walk: no byte is streamed for it, nothing is written, and the walker goes idle.
- R3: Buffer bytes leave in ascending address order; the byte at address A comes from the memory word at A with bits 1:0 cleared, lane A mod 4 (bits 8*(A mod 4)+7 down to 8*(A mod 4)). Any buffer alignment is accepted, and a zero-length descriptor adds no bytes.
- R4: The fragments of all descriptors up to and including the one with bit 15 set form one frame; `tx_last` is high only on the final byte of that descriptor.
- R5: At frame end, word 1 of the frame's first descriptor is read again, written back with bit 31 set and all other bits unchanged; no other descriptor of the frame is written; `fr_done` pulses in the cycle after the write acknowledge.
- R6: The next descriptor is at P+8, or at the queue base when the current descriptor has bit 30 set; after a frame the ring pointer moves past its final descriptor and walking continues at once.
- R7: While `tx_enable` is low the walker is idle from the next cycle on, the ring pointer is reloaded from `q_base`, and `tx_start` is ignored; after reset the walker is idle.
- R8: A frame is limited to MAX_FRAME bytes (default 2048): the byte with index MAX_FRAME-1 carries `tx_last`, later bytes of the frame are dropped, and `fr_trunc` is high with `fr_done` only if a byte was dropped.
- R9: While `tx_valid` is high and `tx_ready` low, `tx_data` and `tx_last` hold their values.
- R10: A memory request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_enable | input | 1 | Transmit enable; low parks the walker and reloads the ring pointer |
| tx_start | input | 1 | Start pulse, honoured in idle while enabled |
| q_base | input | AW | Ring base byte address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Stream sink ready |
| fr_done | output | 1 | One-cycle pulse after a frame's write-back |
| fr_trunc | output | 1 | Frame was truncated (valid with fr_done) |

## Verification
A read acknowledge is taken on a clock edge, so the next request or the first byte of a fetched word appears in the cycle after it. `fr_done` and `fr_trunc` rise one cycle after the write acknowledge. The bench samples on the falling edge and logs every accepted byte, read address and write. It compares those logs with values rebuilt from the descriptor images only after the walker has been quiet for a dozen cycles. Backpressure and request-hold behaviour is compared against the previous falling-edge sample, so each check lands exactly one cycle after the state it tests.

// File: rtl/txd_pkg.sv
package txd_pkg;

  // control word field positions (software-visible layout)
  localparam int LEN_BITS  = 14;
  localparam int FIN_BIT   = 15;
  localparam int WRAP_BIT  = 30;
  localparam int OWNED_BIT = 31;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DW0,
    ST_DW1,
    ST_CHK,
    ST_BUF,
    ST_EMIT,
    ST_DEND,
    ST_WBRD,
    ST_WBWR
  } walk_st_e;

  typedef struct packed {
    logic                owned;
    logic                wrap;
    logic [13:0]         rsv_hi;
    logic                fin;
    logic                rsv_lo;
    logic [LEN_BITS-1:0] len;
  } dctl_t;

  function automatic dctl_t ctl_decode(input logic [31:0] w);
    dctl_t c;
    c = w;
    return c;
  endfunction

  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
    return w[8*lane +: 8];
  endfunction

  function automatic logic [31:0] mark_owned(input logic [31:0] w);
    logic [31:0] r;
    r = w;
    r[OWNED_BIT] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_enable,
  input  logic [AW-1:0] q_base,
  input  logic          walk_load,
  input  logic          walk_step,
  input  logic          step_wrap,
  input  logic          head_commit,
  output logic [AW-1:0] head_o,
  output logic [AW-1:0] walk_o
);

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] cur,
                                               input logic [AW-1:0] base,
                                               input logic wrap);
    return wrap ? base : cur + AW'(DESC_BYTES);
  endfunction

  logic [AW-1:0] head_q, walk_q;
  logic [AW-1:0] walk_next;

  assign walk_next = step_addr(walk_q, q_base, step_wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      walk_q <= '0;
    end else if (!tx_enable) begin
      head_q <= q_base;
      walk_q <= q_base;
    end else begin
      if (head_commit) head_q <= walk_next;
      if (walk_load)      walk_q <= head_q;
      else if (walk_step) walk_q <= walk_next;
    end
  end

  assign head_o = head_q;
  assign walk_o = walk_q;

  AST_COMMIT_WITH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    head_commit |-> walk_step && !walk_load); // R6

endmodule

// File: rtl/txd_byte_lane.sv
module txd_byte_lane #(
  parameter int AW    = 32,
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_clr,
  input  logic             word_load,
  input  logic [31:0]      word_in,
  input  logic             adv,
  input  logic [AW-1:0]    buf_addr,
  input  logic [LEN_W-1:0] len,
  output logic [7:0]       byte_o,
  output logic [AW-1:0]    fetch_addr_o,
  output logic             at_end_o,
  output logic             next_fetch_o
);
  import txd_pkg::*;

  logic [LEN_W-1:0] idx_q;
  logic [31:0]      word_q;
  logic [AW-1:0]    cur_addr;

  assign cur_addr     = buf_addr + AW'(idx_q);
  assign fetch_addr_o = {cur_addr[AW-1:2], 2'b00};
  assign byte_o       = lane_byte(word_q, cur_addr[1:0]);
  assign at_end_o     = (idx_q == len - LEN_W'(1));
  assign next_fetch_o = (cur_addr[1:0] == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      word_q <= '0;
    end else begin
      if (idx_clr)  idx_q <= '0;
      else if (adv) idx_q <= idx_q + LEN_W'(1);
      if (word_load) word_q <= word_in;
    end
  end

  AST_ADV_INSIDE_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> idx_q < len); // R3

endmodule

// File: rtl/txd_frame_cnt.sv
module txd_frame_cnt #(
  parameter int MAX_FRAME = 2048,
  parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  input  logic drop,
  output logic at_limit_o,
  output logic full_o,
  output logic trunc_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             trunc_q;

  assign at_limit_o = (cnt_q == CNT_W'(MAX_FRAME - 1));
  assign full_o     = (cnt_q == CNT_W'(MAX_FRAME));
  assign trunc_o    = trunc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      trunc_q <= 1'b0;
    end else if (clr) begin
      cnt_q   <= '0;
      trunc_q <= 1'b0;
    end else begin
      if (inc)  cnt_q   <= cnt_q + CNT_W'(1);
      if (drop) trunc_q <= 1'b1;
    end
  end

  AST_NO_COUNT_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !full_o); // R8

endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker #(
  parameter int AW        = 32,
  parameter int MAX_FRAME = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_enable,
  input  logic          tx_start,
  input  logic [AW-1:0] q_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          fr_done,
  output logic          fr_trunc
);
  import txd_pkg::*;

  localparam int CNT_W      = $clog2(MAX_FRAME + 1);
  localparam int DESC_BYTES = 8;
  localparam int CTL_OFS    = 4;

  walk_st_e      st_q, st_d;
  logic [AW-1:0] buf_q;
  dctl_t         ctl_q;
  logic [31:0]   wb_q;
  logic          done_q, trunc_out_q;

  // internal events, named for the assertions
  logic walk_load, walk_step, head_commit;
  logic fc_clr, fc_inc, fc_drop;
  logic idx_clr, word_load, adv;
  logic buf_ld, ctl_ld, wb_ld, done_set;

  logic [AW-1:0] head, walk, fetch_addr;
  logic [7:0]    lane_b;
  logic          lane_end, next_fetch;
  logic          fc_at_limit, fc_full, fc_trunc;
  logic          unused_rsv;

  assign unused_rsv = ^{ctl_q.rsv_hi, ctl_q.rsv_lo};

  txd_ring_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_enable   (tx_enable),
    .q_base      (q_base),
    .walk_load   (walk_load),
    .walk_step   (walk_step),
    .step_wrap   (ctl_q.wrap),
    .head_commit (head_commit),
    .head_o      (head),
    .walk_o      (walk)
  );

  txd_byte_lane #(.AW(AW), .LEN_W(LEN_BITS)) u_lane (
    .clk          (clk),
    .rst_n        (rst_n),
    .idx_clr      (idx_clr),
    .word_load    (word_load),
    .word_in      (mem_rdata),
    .adv          (adv),
    .buf_addr     (buf_q),
    .len          (ctl_q.len),
    .byte_o       (lane_b),
    .fetch_addr_o (fetch_addr),
    .at_end_o     (lane_end),
    .next_fetch_o (next_fetch)
  );

  txd_frame_cnt #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (fc_clr),
    .inc        (fc_inc),
    .drop       (fc_drop),
    .at_limit_o (fc_at_limit),
    .full_o     (fc_full),
    .trunc_o    (fc_trunc)
  );

  // next state and strobes
  always_comb begin
    st_d        = st_q;
    walk_load   = 1'b0;
    walk_step   = 1'b0;
    head_commit = 1'b0;
    fc_clr      = 1'b0;
    fc_inc      = 1'b0;
    fc_drop     = 1'b0;
    idx_clr     = 1'b0;
    word_load   = 1'b0;
    adv         = 1'b0;
    buf_ld      = 1'b0;
    ctl_ld      = 1'b0;
    wb_ld       = 1'b0;
    done_set    = 1'b0;
    if (!tx_enable) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (tx_start) begin
          walk_load = 1'b1;
          fc_clr    = 1'b1;
          st_d      = ST_DW0;
        end
        ST_DW0: if (mem_ack) begin
          buf_ld = 1'b1;
          st_d   = ST_DW1;
        end
        ST_DW1: if (mem_ack) begin
          ctl_ld = 1'b1;
          st_d   = ST_CHK;
        end
        ST_CHK: begin
          if (ctl_q.owned) begin
            st_d = ST_IDLE;
          end else if (ctl_q.len == '0) begin
            st_d = ST_DEND;
          end else if (fc_full) begin
            fc_drop = 1'b1;
            st_d    = ST_DEND;
          end else begin
            idx_clr = 1'b1;
            st_d    = ST_BUF;
          end
        end
        ST_BUF: if (mem_ack) begin
          word_load = 1'b1;
          st_d      = ST_EMIT;
        end
        ST_EMIT: if (tx_ready) begin
          adv    = 1'b1;
          fc_inc = 1'b1;
          if (lane_end) begin
            st_d = ST_DEND;
          end else if (fc_at_limit) begin
            fc_drop = 1'b1;
            st_d    = ST_DEND;
          end else if (next_fetch) begin
            st_d = ST_BUF;
          end
        end
        ST_DEND: begin
          if (ctl_q.fin) begin
            st_d = ST_WBRD;
          end else begin
            walk_step = 1'b1;
            st_d      = ST_DW0;
          end
        end
        ST_WBRD: if (mem_ack) begin
          wb_ld = 1'b1;
          st_d  = ST_WBWR;
        end
        ST_WBWR: if (mem_ack) begin
          head_commit = 1'b1;
          walk_step   = 1'b1;
          fc_clr      = 1'b1;
          done_set    = 1'b1;
          st_d        = ST_DW0;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      buf_q       <= '0;
      ctl_q       <= '0;
      wb_q        <= '0;
      done_q      <= 1'b0;
      trunc_out_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      done_q      <= done_set;
      trunc_out_q <= done_set & fc_trunc;
      if (buf_ld) buf_q <= mem_rdata[AW-1:0];
      if (ctl_ld) ctl_q <= ctl_decode(mem_rdata);
      if (wb_ld)  wb_q  <= mark_owned(mem_rdata);
    end
  end

  // memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = wb_q;
    case (st_q)
      ST_DW0:  begin mem_req = 1'b1; mem_addr = walk; end
      ST_DW1:  begin mem_req = 1'b1; mem_addr = walk + AW'(CTL_OFS); end
      ST_BUF:  begin mem_req = 1'b1; mem_addr = fetch_addr; end
      ST_WBRD: begin mem_req = 1'b1; mem_addr = head + AW'(CTL_OFS); end
      ST_WBWR: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = head + AW'(CTL_OFS); end
      default: ;
    endcase
  end

  // byte stream
  assign tx_valid = (st_q == ST_EMIT);
  assign tx_data  = lane_b;
  assign tx_last  = (st_q == ST_EMIT) && ((lane_end && ctl_q.fin) || fc_at_limit);
  assign fr_done  = done_q;
  assign fr_trunc = trunc_out_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !tx_enable)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !tx_enable)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R9
  AST_WB_MARKS_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[OWNED_BIT]); // R5
  AST_DONE_AFTER_WACK: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done |-> $past(mem_req && mem_we && mem_ack)); // R5
  AST_OFF_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> !mem_req && !tx_valid); // R7
  AST_TRUNC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fr_trunc |-> fr_done); // R8

endmodule

// File: tb/txd_ring_walker_tb.sv
module txd_ring_walker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 32;
  localparam int MAXF       = 2048;
  localparam int MEM_WORDS  = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_enable = 1'b0;
  logic          tx_start = 1'b0;
  logic [AW-1:0] q_base = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          mem_ack = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic          tx_valid, tx_last, fr_done, fr_trunc;
  logic [7:0]    tx_data;
  logic          tx_ready = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  txd_ring_walker #(.AW(AW), .MAX_FRAME(MAXF)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .tx_start(tx_start), .q_base(q_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .fr_done(fr_done), .fr_trunc(fr_trunc)
  );

  // memory model: acknowledge one cycle after a request is seen
  logic [31:0] mem [0:MEM_WORDS-1];
  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && !mem_ack) begin
      mem_rdata <= mem[mem_addr[13:2]];
      if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
    end
  end

  function automatic logic [7:0] pb(input int a);
    return 8'((a * 29) ^ (a >> 6));
  endfunction

  int n_chk = 0;
  int n_fail = 0;
  int rdy_mode = 0;
  int cyc = 0;

  initial forever begin
    @(negedge clk);
    cyc++;
    tx_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
  end

  // observation logs
  logic [7:0] got_b[$];
  bit         got_l[$];
  logic [7:0] exp_b[$];
  bit         exp_l[$];
  int rd_n = 0, wr_n = 0, done_n = 0, trunc_n = 0, stall_n = 0;
  int viol_mem = 0, viol_str = 0;
  logic [31:0] first_rd = '0, last_rd = '0, last_wr = '0;
  logic        p_req = 0, p_ack = 0, p_we = 0, p_val = 0, p_rdy = 0, p_last = 0;
  logic [31:0] p_addr = '0, p_wd = '0;
  logic [7:0]  p_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        got_b.push_back(tx_data);
        got_l.push_back(tx_last);
      end
      if (tx_valid && !tx_ready) stall_n++;
      if (mem_req && mem_ack && !mem_we) begin
        if (rd_n == 0) first_rd = mem_addr;
        last_rd = mem_addr;
        rd_n++;
      end
      if (mem_req && mem_ack && mem_we) begin
        last_wr = mem_addr;
        wr_n++;
      end
      if (fr_done) done_n++;
      if (fr_done && fr_trunc) trunc_n++;
      if (p_req && !p_ack && tx_enable &&
          (!mem_req || mem_addr != p_addr || mem_we != p_we || (p_we && mem_wdata != p_wd)))
        viol_mem++;
      if (p_val && !p_rdy && tx_enable &&
          (!tx_valid || tx_data != p_data || tx_last != p_last))
        viol_str++;
    end
    p_req = mem_req; p_ack = mem_ack; p_we = mem_we; p_addr = mem_addr; p_wd = mem_wdata;
    p_val = tx_valid; p_rdy = tx_ready; p_data = tx_data; p_last = tx_last;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic clear_logs();
    got_b.delete(); got_l.delete(); exp_b.delete(); exp_l.delete();
    rd_n = 0; wr_n = 0; done_n = 0; trunc_n = 0; stall_n = 0;
    viol_mem = 0; viol_str = 0;
  endtask

  task automatic set_desc(input int a, input int bufa, input int len, input bit fin,
                          input bit wrap, input bit owned);
    mem[a >> 2]       = 32'(bufa);
    mem[(a >> 2) + 1] = {owned, wrap, 14'b0, fin, 1'b0, 14'(len)};
  endtask

  task automatic add_frag(input int bufa, input int len, input bit fin);
    for (int i = 0; i < len; i++) begin
      exp_b.push_back(pb(bufa + i));
      exp_l.push_back(fin && (i == len - 1));
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
  endtask

  task automatic set_base(input int b);
    @(negedge clk); tx_enable = 1'b0; q_base = 32'(b);
    @(negedge clk); tx_enable = 1'b1;
  endtask

  task automatic wait_quiet(input string tag);
    int quiet = 0;
    int n = 0;
    while (quiet < 12 && n < 20000) begin
      @(negedge clk);
      n++;
      if (mem_req || tx_valid) quiet = 0; else quiet++;
    end
    chk(n < 20000, {tag, " walker settles"}, n, 0);
  endtask

  task automatic cmp_stream(input string tag);
    int mism = 0;
    int lmis = 0;
    chk(got_b.size() == exp_b.size(), {tag, " byte count"}, got_b.size(), exp_b.size());
    for (int i = 0; i < got_b.size() && i < exp_b.size(); i++) begin
      if (got_b[i] != exp_b[i]) begin
        if (mism == 0) $display("  first byte difference at %0d: %0h vs %0h", i, got_b[i], exp_b[i]);
        mism++;
      end
      if (got_l[i] != exp_l[i]) lmis++;
    end
    chk(mism == 0, {tag, " byte values"}, mism, 0);
    chk(lmis == 0, {tag, " last marker placement"}, lmis, 0);
  endtask

  // R7: reset state
  task automatic t_reset();
    chk(!mem_req && !tx_valid && !fr_done && !fr_trunc, "R7 idle after reset",
        {mem_req, tx_valid, fr_done, fr_trunc}, 0);
  endtask

  // R1 R3 R4 R5 R6: single-descriptor frame
  task automatic t_single();
    logic [31:0] orig;
    q_base = 32'h100;
    set_desc(32'h100, 32'h400, 5, 1, 0, 0);
    set_desc(32'h108, 0, 0, 0, 0, 1);
    orig = mem[32'h104 >> 2];
    @(negedge clk); tx_enable = 1'b1;
    clear_logs();
    add_frag(32'h400, 5, 1);
    pulse_start();
    wait_quiet("R4 single");
    cmp_stream("R3 R4 single");
    chk(mem[32'h104 >> 2] == (orig | 32'h8000_0000), "R5 owned bit written back", mem[32'h104 >> 2], orig | 32'h8000_0000);
    chk(done_n == 1, "R5 done pulses", done_n, 1);
    chk(first_rd == 32'h100, "R1 first descriptor read at pointer", first_rd, 32'h100);
    chk(last_rd == 32'h10C, "R6 walk continues to P+8", last_rd, 32'h10C);
  endtask

  // R3 R4 R5 R9 R10: fragmented, unaligned, zero-length, with backpressure
  task automatic t_multi();
    logic [31:0] o1, o2, o3;
    set_desc(32'h108, 32'h501, 6, 0, 0, 0);
    set_desc(32'h110, 32'h5F0, 0, 0, 0, 0);
    set_desc(32'h118, 32'h602, 3, 0, 0, 0);
    set_desc(32'h120, 32'h6FF, 4, 1, 0, 0);
    set_desc(32'h128, 0, 0, 0, 0, 1);
    o1 = mem[32'h114 >> 2]; o2 = mem[32'h11C >> 2]; o3 = mem[32'h124 >> 2];
    clear_logs();
    add_frag(32'h501, 6, 0);
    add_frag(32'h602, 3, 0);
    add_frag(32'h6FF, 4, 1);
    rdy_mode = 1;
    pulse_start();
    wait_quiet("R4 multi");
    rdy_mode = 0;
    cmp_stream("R3 R4 multi");
    chk(mem[32'h10C >> 2][31] == 1'b1, "R5 first descriptor owned", mem[32'h10C >> 2], 32'h8000_0000);
    chk(mem[32'h114 >> 2] == o1 && mem[32'h11C >> 2] == o2 && mem[32'h124 >> 2] == o3,
        "R5 later descriptors untouched", mem[32'h124 >> 2], o3);
    chk(wr_n == 1 && last_wr == 32'h10C, "R5 single write to first descriptor", last_wr, 32'h10C);
    chk(stall_n > 0 && viol_str == 0, "R9 stream held under backpressure", viol_str, 0);
    chk(viol_mem == 0, "R10 request held until ack", viol_mem, 0);
    chk(last_rd == 32'h12C, "R2 walk ends at owned descriptor", last_rd, 32'h12C);
  endtask

  // R7 R6: start ignored while disabled; base reload; wrap
  task automatic t_wrap();
    @(negedge clk); tx_enable = 1'b0; q_base = 32'h200;
    set_desc(32'h200, 32'h440, 2, 1, 1, 0);
    set_desc(32'h208, 32'h480, 2, 1, 0, 0);
    clear_logs();
    pulse_start();
    repeat (20) @(negedge clk);
    chk(rd_n == 0 && !mem_req, "R7 start ignored while disabled", rd_n, 0);
    @(negedge clk); tx_enable = 1'b1;
    clear_logs();
    add_frag(32'h440, 2, 1);
    pulse_start();
    wait_quiet("R6 wrap");
    cmp_stream("R6 wrap frame");
    chk(first_rd == 32'h200, "R7 pointer reloaded from base", first_rd, 32'h200);
    chk(last_rd == 32'h204, "R6 wrap returns to base", last_rd, 32'h204);
    chk(mem[32'h20C >> 2][31] == 1'b0 && done_n == 1, "R6 descriptor after wrap not used", mem[32'h20C >> 2], 0);
  endtask

  // R5 R6: two frames back to back
  task automatic t_two();
    logic [31:0] o;
    set_base(32'h300);
    set_desc(32'h300, 32'h800, 3, 1, 0, 0);
    set_desc(32'h308, 32'h900, 2, 0, 0, 0);
    set_desc(32'h310, 32'hA00, 1, 1, 0, 0);
    set_desc(32'h318, 0, 0, 0, 0, 1);
    o = mem[32'h314 >> 2];
    clear_logs();
    add_frag(32'h800, 3, 1);
    add_frag(32'h900, 2, 0);
    add_frag(32'hA00, 1, 1);
    pulse_start();
    wait_quiet("R6 two frames");
    cmp_stream("R4 two frames");
    chk(done_n == 2 && wr_n == 2, "R5 one write-back per frame", wr_n, 2);
    chk(mem[32'h304 >> 2][31] && mem[32'h30C >> 2][31] && mem[32'h314 >> 2] == o,
        "R5 heads owned, tail untouched", mem[32'h314 >> 2], o);
    chk(last_rd == 32'h31C, "R6 pointer past both frames", last_rd, 32'h31C);
  endtask

  // R8: truncation and the exact-limit boundary
  task automatic t_trunc();
    set_base(32'h380);
    set_desc(32'h380, 32'h1000, 1500, 0, 0, 0);
    set_desc(32'h388, 32'h2000, 1000, 1, 0, 0);
    set_desc(32'h390, 0, 0, 0, 0, 1);
    clear_logs();
    add_frag(32'h1000, 1500, 0);
    for (int i = 0; i < MAXF - 1500; i++) begin
      exp_b.push_back(pb(32'h2000 + i));
      exp_l.push_back(i == MAXF - 1500 - 1);
    end
    pulse_start();
    wait_quiet("R8 long");
    cmp_stream("R8 truncated frame");
    chk(trunc_n == 1 && done_n == 1, "R8 truncation flagged", trunc_n, 1);
    set_desc(32'h390, 32'h3000, MAXF, 1, 0, 0);
    set_desc(32'h398, 0, 0, 0, 0, 1);
    clear_logs();
    add_frag(32'h3000, MAXF, 1);
    pulse_start();
    wait_quiet("R8 exact");
    cmp_stream("R8 exact-limit frame");
    chk(trunc_n == 0 && done_n == 1, "R8 exact limit not flagged", trunc_n, 0);
  endtask

  // R2: owned descriptor at the pointer
  task automatic t_owned();
    clear_logs();
    pulse_start();
    wait_quiet("R2 owned");
    chk(got_b.size() == 0 && wr_n == 0 && done_n == 0, "R2 nothing sent or written", got_b.size(), 0);
    chk(rd_n == 2 && last_rd == 32'h39C, "R2 only the descriptor read", rd_n, 2);
  endtask

  bit finished = 0;

  initial begin
    for (int w = 0; w < MEM_WORDS; w++)
      mem[w] = {pb(4*w + 3), pb(4*w + 2), pb(4*w + 1), pb(4*w)};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_wrap();
    t_two();
    t_trunc();
    t_owned();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule